// File: doc/BRIEF.md
# Slave FIFO Loopback Master

This block is the FPGA-side master of a synchronous slave FIFO port on a USB peripheral controller. It uses a multiplexed address and data scheme. The controller offers two DMA sockets. The master reads from one socket and writes to the other. Each socket reports a DMA-ready flag (active high) and a partial, or watermark, flag. The partial flag is active low: it is high while the socket is still above its watermark. The master pulls a burst from the read socket into a small internal buffer. After one idle turnaround it writes the captured words back to the write socket, which makes a loopback path.

The master does not wait for an empty or full indication to stop a burst. It stops on the partial flag. On the clock edge at which it first sees that flag low, it commits to a fixed number of further words, and that number is derived at elaboration from the watermark setting and the bus width. Every flag is registered once on the interface clock before any decision uses it. A parameter set that gives a negative word count is rejected at elaboration.

Top module: `sfl_loopback_master`

## Requirements
- R1: Reset state:
  - `ce_n_o`, `oe_n_o` and `we_n_o` are all 1.
  - `fifo_wdata_oe_o` is 0.
- R2: A read burst begins only when all of these hold:
  - the buffer is empty;
  - the registered read-ready flag is high;
  - the registered read partial flag is high.
  
  While the buffer is empty and either flag is low, `ce_n_o` stays 1.
- R3: A read burst has three steps:
  - `ce_n_o` falls with `sock_addr_o` = 3 and `oe_n_o` = 1.
  - `oe_n_o` goes to 0 one cycle later.
  - A word is captured at every rising edge at which `oe_n_o` = 0 and `rdy_i` = 1.
- R4: Take the first rising edge at which the registered read partial flag is low. Any word at that edge still counts as normal. Exactly TAIL = WMARK*(32/DATA_W)-4 further words are read after it, which is 2 for the defaults. Then the burst ends.
- R5: When a read burst ends, `oe_n_o` and `ce_n_o` rise at the same edge. `we_n_o` is 1 at that point. All three strobes then stay 1 for at least one cycle.
- R6: A read burst ends after the word that fills the buffer (BUF_DEPTH = 16 words), even if the partial flag is still high. This also holds when that word is also the last tail word.
- R7: A write burst begins only when both of these hold:
  - the buffer is not empty;
  - the registered write-ready flag is high.
  
  `ce_n_o` falls with `sock_addr_o` = 0, and `we_n_o` goes to 0 one cycle later.
- R8: `fifo_wdata_oe_o` is 1 exactly when `we_n_o` = 0 and `rdy_i` = 1. At all other times `fifo_wdata_o` is 0. The words written are the captured words, in capture order.
- R9: Take the first rising edge at which the registered write partial flag is low. Exactly TAIL further words are written after it. Then the burst ends and the remaining buffer contents are discarded.
- R10: A write burst ends early, with no extra strobe, once every captured word has been written. The buffer is empty after every write burst, so the next read fills it again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_rdata_i | input | DATA_W | Data bus from the controller during reads |
| fifo_wdata_o | output | DATA_W | Data bus to the controller during writes |
| fifo_wdata_oe_o | output | 1 | Output enable for the write data bus |
| sock_addr_o | output | ADDR_W | Socket select: 3 selects the read socket, 0 the write socket |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Read output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| rdy_i | input | 1 | Controller ready; a word moves on each edge at which it is high |
| rd_ready_i | input | 1 | Read socket DMA-ready flag |
| rd_partial_n_i | input | 1 | Read socket watermark flag, active low |
| wr_ready_i | input | 1 | Write socket DMA-ready flag |
| wr_partial_n_i | input | 1 | Write socket watermark flag, active low |

## Verification
Two exit conditions can become true in the same cycle:
- on the read side, the final tail word can be the word that fills the buffer;
- on the write side, the final tail word can be the last word left in the buffer.

Both cases are provoked by choosing the fill level at which the slave model drops the partial flag. The read burst uses a level of 12 against a 16-word buffer, and the write burst uses a level that uses up the buffer exactly at the end of the tail. Each case is judged on three points: the transferred word count matches the count both conditions predict, the strobes return high cleanly, and the written words equal the captured ones. Other bursts separate the two conditions so that each exit is also seen alone.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT_RDY,
      ST_RD_DATA,
      ST_RD_TAIL,
      ST_RD_END,
      ST_WR_SETUP,
      ST_WR_WAIT_RDY,
      ST_WR_DATA,
      ST_WR_TAIL,
      ST_WR_END
   } lb_state_e;

   // bit positions inside the registered flag vector
   localparam int FLG_RD_RDY  = 0;
   localparam int FLG_RD_PART = 1;
   localparam int FLG_WR_RDY  = 2;
   localparam int FLG_WR_PART = 3;
   localparam int FLG_COUNT   = 4;

   // words still allowed once the partial flag is seen low
   function automatic int tail_words(input int wmark, input int data_w);
      return wmark * (32 / data_w) - 4;
   endfunction

endpackage

// File: rtl/sfl_flag_sampler.sv
module sfl_flag_sampler #(
   parameter int N_FLAGS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] flags_i,
   output logic [N_FLAGS-1:0] flags_q
);

   for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[g] <= 1'b0;
         else        flags_q[g] <= flags_i[g];
      end
   end

endmodule

// File: rtl/sfl_buffer.sv
module sfl_buffer #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_adv,
   input  logic              clear,
   output logic [DATA_W-1:0] rd_data,
   output logic              fill_zero,
   output logic              last_slot,
   output logic              last_word
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("sfl_buffer: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  fill_q;
   logic [CNT_W-1:0]  rptr_q;
   logic [CNT_W-1:0]  left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         rptr_q <= '0;
      end else if (clear) begin
         fill_q <= '0;
         rptr_q <= '0;
      end else begin
         if (wr_en)  fill_q <= fill_q + 1'b1;
         if (rd_adv) rptr_q <= rptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[fill_q[IDX_W-1:0]] <= wr_data;
   end

   assign left      = fill_q - rptr_q;
   assign rd_data   = mem[rptr_q[IDX_W-1:0]];
   assign fill_zero = (fill_q == '0);
   assign last_slot = (fill_q == CNT_W'(DEPTH - 1));
   assign last_word = (left == CNT_W'(1));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (fill_q < CNT_W'(DEPTH)));

   assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_adv |-> (left != '0));

endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
   import sfl_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int RD_ADDR = 3,
   parameter int WR_ADDR = 0,
   parameter int TAIL    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rdy,
   input  logic [FLG_COUNT-1:0] flags_q,
   input  logic                 fill_zero,
   input  logic                 last_slot,
   input  logic                 last_word,
   output logic                 ce_n,
   output logic                 oe_n,
   output logic                 we_n,
   output logic [ADDR_W-1:0]    addr,
   output logic                 cap,
   output logic                 adv,
   output logic                 clear
);

   localparam bit TAIL_NONE = (TAIL <= 0);
   localparam int TW        = (TAIL > 0) ? $clog2(TAIL + 1) : 1;

   lb_state_e st_q, st_d;
   logic rd_rdy_q, rd_part_q, wr_rdy_q, wr_part_q;
   logic xfer_rd, xfer_wr, tail_last;

   assign rd_rdy_q  = flags_q[FLG_RD_RDY];
   assign rd_part_q = flags_q[FLG_RD_PART];
   assign wr_rdy_q  = flags_q[FLG_WR_RDY];
   assign wr_part_q = flags_q[FLG_WR_PART];

   // strobe and address decode from state
   always_comb begin
      ce_n = 1'b0;
      oe_n = 1'b1;
      we_n = 1'b1;
      addr = ADDR_W'(WR_ADDR);
      case (st_q)
         ST_IDLE, ST_WR_END: ce_n = 1'b1;
         ST_RD_END: begin
            ce_n = 1'b1;
            addr = ADDR_W'(RD_ADDR);
         end
         ST_RD_SETUP: addr = ADDR_W'(RD_ADDR);
         ST_RD_WAIT_RDY, ST_RD_DATA, ST_RD_TAIL: begin
            oe_n = 1'b0;
            addr = ADDR_W'(RD_ADDR);
         end
         ST_WR_WAIT_RDY, ST_WR_DATA, ST_WR_TAIL: we_n = 1'b0;
         default: ;
      endcase
   end

   assign xfer_rd = !oe_n && rdy;
   assign xfer_wr = !we_n && rdy;
   assign cap     = xfer_rd;
   assign adv     = xfer_wr;
   assign clear   = (st_q == ST_WR_END);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: begin
            if (!fill_zero) begin
               if (wr_rdy_q) st_d = ST_WR_SETUP;
            end else if (rd_rdy_q && rd_part_q) begin
               st_d = ST_RD_SETUP;
            end
         end
         ST_RD_SETUP: st_d = ST_RD_WAIT_RDY;
         ST_RD_WAIT_RDY, ST_RD_DATA: begin
            if (xfer_rd && last_slot)  st_d = ST_RD_END;
            else if (!rd_part_q)       st_d = TAIL_NONE ? ST_RD_END : ST_RD_TAIL;
            else if (xfer_rd)          st_d = ST_RD_DATA;
         end
         ST_RD_TAIL: if (xfer_rd && (last_slot || tail_last)) st_d = ST_RD_END;
         ST_RD_END:  st_d = ST_IDLE;
         ST_WR_SETUP: st_d = ST_WR_WAIT_RDY;
         ST_WR_WAIT_RDY, ST_WR_DATA: begin
            if (xfer_wr && last_word)  st_d = ST_WR_END;
            else if (!wr_part_q)       st_d = TAIL_NONE ? ST_WR_END : ST_WR_TAIL;
            else if (xfer_wr)          st_d = ST_WR_DATA;
         end
         ST_WR_TAIL: if (xfer_wr && (last_word || tail_last)) st_d = ST_WR_END;
         ST_WR_END:  st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // tail counter exists only when words follow the flag
   if (TAIL > 0) begin : g_tail
      logic [TW-1:0] tail_cnt_q;
      logic          in_tail;
      assign in_tail = (st_q == ST_RD_TAIL) || (st_q == ST_WR_TAIL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   tail_cnt_q <= '0;
         else if (!in_tail)            tail_cnt_q <= '0;
         else if (xfer_rd || xfer_wr)  tail_cnt_q <= tail_cnt_q + 1'b1;
      end

      assign tail_last = (tail_cnt_q == TW'(TAIL - 1));

      assert_tail_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
         in_tail |-> (tail_cnt_q < TW'(TAIL)));
   end else begin : g_no_tail
      assign tail_last = 1'b1;
   end

   assert_read_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ce_n) && addr == ADDR_W'(RD_ADDR)) |-> $past(rd_rdy_q && rd_part_q));

   assert_write_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ce_n) && addr == ADDR_W'(WR_ADDR)) |-> $past(wr_rdy_q));

   assert_end_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> (ce_n && we_n));

endmodule

// File: rtl/sfl_loopback_master.sv
module sfl_loopback_master
   import sfl_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int WMARK     = 3,
   parameter int BUF_DEPTH = 16,
   parameter int RD_ADDR   = 3,
   parameter int WR_ADDR   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] fifo_rdata_i,
   output logic [DATA_W-1:0] fifo_wdata_o,
   output logic              fifo_wdata_oe_o,
   output logic [ADDR_W-1:0] sock_addr_o,
   output logic              ce_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   input  logic              rdy_i,
   input  logic              rd_ready_i,
   input  logic              rd_partial_n_i,
   input  logic              wr_ready_i,
   input  logic              wr_partial_n_i
);

   localparam int TAIL = tail_words(WMARK, DATA_W);

   if ((32 % DATA_W) != 0) begin : g_bad_width
      $error("sfl_loopback_master: DATA_W must divide 32");
   end
   if (TAIL < 0) begin : g_bad_tail
      $error("sfl_loopback_master: WMARK and DATA_W give a negative tail count");
   end
   if (RD_ADDR >= (1 << ADDR_W) || WR_ADDR >= (1 << ADDR_W) || RD_ADDR == WR_ADDR) begin : g_bad_addr
      $error("sfl_loopback_master: socket addresses must differ and fit ADDR_W");
   end

   logic [FLG_COUNT-1:0] flags_raw, flags_q;
   logic [DATA_W-1:0]    buf_rdata;
   logic fill_zero, last_slot, last_word;
   logic cap, adv, clear;

   assign flags_raw[FLG_RD_RDY]  = rd_ready_i;
   assign flags_raw[FLG_RD_PART] = rd_partial_n_i;
   assign flags_raw[FLG_WR_RDY]  = wr_ready_i;
   assign flags_raw[FLG_WR_PART] = wr_partial_n_i;

   sfl_flag_sampler #(.N_FLAGS(FLG_COUNT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags_raw),
      .flags_q (flags_q)
   );

   sfl_buffer #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cap),
      .wr_data   (fifo_rdata_i),
      .rd_adv    (adv),
      .clear     (clear),
      .rd_data   (buf_rdata),
      .fill_zero (fill_zero),
      .last_slot (last_slot),
      .last_word (last_word)
   );

   sfl_ctrl #(
      .ADDR_W  (ADDR_W),
      .RD_ADDR (RD_ADDR),
      .WR_ADDR (WR_ADDR),
      .TAIL    (TAIL)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rdy       (rdy_i),
      .flags_q   (flags_q),
      .fill_zero (fill_zero),
      .last_slot (last_slot),
      .last_word (last_word),
      .ce_n      (ce_n_o),
      .oe_n      (oe_n_o),
      .we_n      (we_n_o),
      .addr      (sock_addr_o),
      .cap       (cap),
      .adv       (adv),
      .clear     (clear)
   );

   assign fifo_wdata_oe_o = adv;
   assign fifo_wdata_o    = adv ? buf_rdata : '0;

endmodule

// File: tb/tb_sfl_loopback_master.sv
module tb_sfl_loopback_master;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 16;
   localparam int WMARK      = 3;
   localparam int DEPTH      = 16;
   localparam int TAIL_EXP   = WMARK * (32 / DW) - 4;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] rdata = '0;
   logic [DW-1:0] wdata;
   logic wdata_oe;
   logic [1:0] addr;
   logic ce_n, oe_n, we_n;
   logic rdy = 1'b0;
   logic rd_ready = 1'b0, rd_part = 1'b0, wr_ready = 1'b0, wr_part = 1'b0;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   // slave model controls and observations
   int rd_level = 0, wr_level = 0, rd_delay = 0;
   int rd_cnt = 0, wr_cnt = 0, low_cnt = 0;
   int addr_err = 0, oe_err = 0, ta_err = 0, end_seen = 0;
   logic [DW-1:0] seed = '0;
   logic [DW-1:0] rd_words [64];
   logic [DW-1:0] wr_words [64];
   bit rd_pend = 1'b0, wr_pend = 1'b0, prev_oe = 1'b1;
   logic [DW-1:0] wr_latched = '0;

   sfl_loopback_master dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .fifo_rdata_i    (rdata),
      .fifo_wdata_o    (wdata),
      .fifo_wdata_oe_o (wdata_oe),
      .sock_addr_o     (addr),
      .ce_n_o          (ce_n),
      .oe_n_o          (oe_n),
      .we_n_o          (we_n),
      .rdy_i           (rdy),
      .rd_ready_i      (rd_ready),
      .rd_partial_n_i  (rd_part),
      .wr_ready_i      (wr_ready),
      .wr_partial_n_i  (wr_part)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // slave: updates at the falling edge, judges after a settle delay
   always begin
      @(negedge clk);
      if (rd_pend) begin
         if (rd_cnt < 64) rd_words[rd_cnt] = rdata;
         rd_cnt++;
      end
      if (wr_pend) begin
         if (wr_cnt < 64) wr_words[wr_cnt] = wr_latched;
         wr_cnt++;
      end
      if (!oe_n || !we_n) low_cnt++;
      else                low_cnt = 0;
      rdy     = (low_cnt > rd_delay);
      rd_part = (rd_cnt < rd_level);
      wr_part = (wr_cnt < wr_level);
      rdata   = seed + DW'(rd_cnt);
      if (!prev_oe && oe_n) begin
         end_seen++;
         if (!ce_n || !we_n) ta_err++;
      end
      prev_oe = oe_n;
      if (!oe_n && (addr != 2'd3 || ce_n)) addr_err++;
      if (!we_n && (addr != 2'd0 || ce_n)) addr_err++;
      #1;
      if (wdata_oe !== (!we_n && rdy)) oe_err++;
      if (!wdata_oe && wdata != '0) oe_err++;
      rd_pend    = !oe_n && rdy;
      wr_pend    = !we_n && rdy;
      wr_latched = wdata;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_ce(input logic lvl, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 300; i++) begin
         if (ce_n == lvl) begin
            ok = 1'b1;
            break;
         end
         tick();
      end
   endtask

   task automatic test_reset();
      chk(ce_n && oe_n && we_n, "R1 strobes in reset", {ce_n, oe_n, we_n}, 7);
      chk(!wdata_oe, "R1 data enable in reset", wdata_oe, 0);
   endtask

   task automatic test_read_gating();
      int lows = 0;
      rd_level = 0;
      rd_ready = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick();
         if (!ce_n) lows++;
      end
      chk(lows == 0, "R2 partial low blocks read", lows, 0);
      rd_ready = 1'b0;
      rd_level = 5;
      lows = 0;
      for (int i = 0; i < 8; i++) begin
         tick();
         if (!ce_n) lows++;
      end
      chk(lows == 0, "R2 ready low blocks read", lows, 0);
   endtask

   // one loopback burst: read with level L, hold write, then write with level WL
   task automatic run_burst(input string name, input int l, input int dly, input int wl,
                            input int exp_rd, input int exp_wr, input string rd_tag,
                            input string wr_tag);
      bit ok;
      int lows = 0, bad = 0;
      rd_cnt = 0; wr_cnt = 0;
      rd_level = l; wr_level = wl; rd_delay = dly;
      seed = DW'(exp_rd * 16'h0111 + 16'h1000);
      addr_err = 0; oe_err = 0; ta_err = 0; end_seen = 0;
      rd_ready = 1'b1;
      wait_ce(1'b0, ok);
      chk(ok && addr == 2'd3 && oe_n, {name, " R3 read setup"}, addr, 3);
      rd_ready = 1'b0;
      tick();
      chk(!oe_n, {name, " R3 OE one cycle after CE"}, oe_n, 0);
      wait_ce(1'b1, ok);
      for (int i = 0; i < 8; i++) begin
         tick();
         if (!ce_n) lows++;
      end
      chk(lows == 0, {name, " R7 write held without ready"}, lows, 0);
      chk(rd_cnt == exp_rd, {name, " ", rd_tag, " read word count"}, rd_cnt, exp_rd);
      chk(end_seen == 1 && ta_err == 0, {name, " R5 read end turnaround"}, ta_err, 0);
      wr_ready = 1'b1;
      wait_ce(1'b0, ok);
      chk(ok && addr == 2'd0 && we_n, {name, " R7 write setup"}, addr, 0);
      wr_ready = 1'b0;
      tick();
      chk(!we_n, {name, " R7 WE one cycle after CE"}, we_n, 0);
      wait_ce(1'b1, ok);
      tick(); tick();
      chk(ok && wr_cnt == exp_wr, {name, " ", wr_tag, " write word count"}, wr_cnt, exp_wr);
      for (int i = 0; i < exp_wr && i < 64; i++)
         if (wr_words[i] !== rd_words[i]) bad++;
      chk(bad == 0, {name, " R8 loopback data order"}, bad, 0);
      chk(addr_err == 0, {name, " R3 socket address while strobed"}, addr_err, 0);
      chk(oe_err == 0, {name, " R8 bus enable only with WE and RDY"}, oe_err, 0);
      chk(ce_n && oe_n && we_n, {name, " R10 strobes idle after write"}, {ce_n, oe_n, we_n}, 7);
   endtask

   initial begin
      repeat (4) tick();
      test_reset();
      rst_n = 1'b1;
      tick();
      test_reset();
      test_read_gating();
      // R4 read tail, R10 write drains the buffer early
      run_burst("A", 5, 3, 40, 5 + 2 + TAIL_EXP, 5 + 2 + TAIL_EXP, "R4", "R10");
      // R9 write tail on its own
      run_burst("B", 6, 2, 1, 6 + 2 + TAIL_EXP, 1 + 2 + TAIL_EXP, "R4", "R9");
      // R9 and R10 at one edge: tail ends on the last stored word
      run_burst("C", 3, 1, 3, 3 + 2 + TAIL_EXP, 3 + 2 + TAIL_EXP, "R4", "R9");
      // R4 and R6 at one edge: tail ends on the word that fills the buffer
      run_burst("D", DEPTH - 2 - TAIL_EXP, 0, 40, DEPTH, DEPTH, "R6", "R10");
      // R6 alone: partial flag never drops
      run_burst("E", 30, 0, 40, DEPTH, DEPTH, "R6", "R10");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end

endmodule